// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block writes bytes into a parallel UV-erasable EPROM, one at a time. A host hands it an address and a target byte over a valid/ready handshake. The sequencer first reads the location. If the byte already matches, it is finished. If a bit would have to go from 0 to 1, it reports that the location is not erased. Otherwise it enters a loop. Each pass raises the programming-voltage request, drives address and data, and gives one fixed-width active-low pulse on the chip-enable/program line. It then drops the voltage request and reads the byte back. The loop ends when the readback matches or the pulse limit is reached.

Pulse width and the readback data-valid delay are given in nanoseconds and turned into clock cycles from a clock-frequency parameter. The sequencer can also run an identity check on request. It raises the high-voltage request for address line 9, reads the manufacturer byte with A0 low and the device byte with A0 high, and compares them with expected values. The high voltages themselves and erasure are produced outside this block.

Top module: `eprom_burner`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle and `id_start` is low. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low on the next cycle.
- R2: Before any pulse, the location is read. If some target bit is 1 where the stored bit is 0, the sequencer gives no pulse and reports error code 1 (not erased) with a try count of 0.
- R3: If the stored byte already equals the target, the sequencer gives no pulse and raises `resp_done` for one cycle with a try count of 0.
- R4: Each program pulse holds `rom_ce_n` low for exactly PULSE_CYC = PULSE_NS*CLK_MHZ/1000 cycles. During the pulse, `vpp_req` and `rom_dq_oe` are high and `rom_oe_n` is high. `vpp_req` and the driven data come up at least one cycle before `rom_ce_n` falls.
- R5: Address and data stay unchanged for the whole pulse.
- R6: After each pulse, `vpp_req` and `rom_dq_oe` drop, and the byte is read back with `rom_ce_n` and `rom_oe_n` low. The data is sampled only after DV_CYC = ceil(DV_NS*CLK_MHZ/1000) cycles of read.
- R7: When a readback matches the target, `resp_done` pulses for one cycle. `resp_tries` then equals the number of pulses given to that address.
- R8: If the readback still differs after MAX_TRY (default 10) pulses, the sequencer reports error code 2 (verify timeout) with `resp_tries` equal to MAX_TRY. It never gives more than MAX_TRY pulses to one address.
- R9: An error holds `resp_err` high with its code, and keeps `req_ready` low, until `err_ack` is seen. The sequencer then returns to idle.
- R10: A pulse on `id_start` while idle raises `a9_hv_req`. The sequencer reads with A0 = 0, expecting 0x8F, then with A0 = 1, expecting 0x85. If both match, `resp_done` pulses with a try count of 0. Otherwise it reports error code 3 (ID mismatch).
- R11: After reset, `req_ready` is 1, `rom_ce_n` and `rom_oe_n` are 1, and `vpp_req`, `a9_hv_req`, `rom_dq_oe`, `resp_done` and `resp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | AW | Target address |
| req_data | input | DW | Target byte |
| id_start | input | 1 | Start the identity check (taken while idle) |
| err_ack | input | 1 | Acknowledges a held error |
| resp_done | output | 1 | One-cycle success pulse |
| resp_err | output | 1 | Error held until acknowledged |
| resp_code | output | 2 | 1 not erased, 2 verify timeout, 3 ID mismatch |
| resp_tries | output | TW | Pulses given to the last address |
| rom_addr | output | AW | Address bus to the EPROM |
| rom_dq_out | output | DW | Data driven during programming |
| rom_dq_oe | output | 1 | Data bus drive enable |
| rom_dq_in | input | DW | Data read from the EPROM |
| rom_ce_n | output | 1 | Chip enable / program pulse, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| vpp_req | output | 1 | Request for programming voltage |
| a9_hv_req | output | 1 | Request for identity voltage on address line 9 |

## Verification
A wrong state or counter in this block shows up at the EPROM pins first. A pulse that is too short or too long shows in the width of the low level on `rom_ce_n`. Sampling too early in a read changes what the sequencer decides within one read window. An off-by-one in the try counter shows as a wrong `resp_tries`, or as an eleventh pulse, on the very address that needs exactly MAX_TRY pulses. The bench's device model records each pulse, checks its width, setup and stability against the requirements, and only returns valid data after the data-valid delay. A mis-sampling sequencer therefore reports wrong results within one request.

// File: rtl/eprom_burner.sv
module eprom_burner #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CLK_MHZ = 125,
  parameter int PULSE_NS = 50000,
  parameter int DV_NS = 100,
  parameter int MAX_TRY = 10,
  parameter logic [7:0] MFR_ID = 8'h8F,
  parameter logic [7:0] DEV_ID = 8'h85,
  localparam int TW = $clog2(MAX_TRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          id_start,
  input  logic          err_ack,
  output logic          resp_done,
  output logic          resp_err,
  output logic [1:0]    resp_code,
  output logic [TW-1:0] resp_tries,
  output logic [AW-1:0] rom_addr,
  output logic [DW-1:0] rom_dq_out,
  output logic          rom_dq_oe,
  input  logic [DW-1:0] rom_dq_in,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          vpp_req,
  output logic          a9_hv_req
);
  localparam int PULSE_CYC = (PULSE_NS * CLK_MHZ) / 1000;
  localparam int DV_RAW = (DV_NS * CLK_MHZ + 999) / 1000;
  localparam int DV_CYC = DV_RAW < 1 ? 1 : DV_RAW;
  localparam int CW = $clog2((PULSE_CYC > DV_CYC ? PULSE_CYC : DV_CYC) + 2);
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] DV_END = CW'(DV_CYC);
  localparam logic [TW-1:0] TRY_LIM = TW'(MAX_TRY);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_SET, S_PULSE, S_REC, S_VER, S_ID0, S_ID1, S_ERR
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] tries;
  logic [1:0]    code_q;
  logic          done_q;

  wire rd_state = (st == S_PRE) || (st == S_VER) || (st == S_ID0) || (st == S_ID1);
  wire rd_ready = rd_state && (cnt == DV_END);
  wire hv_state = (st == S_SET) || (st == S_PULSE);

  assign req_ready  = (st == S_IDLE) && !id_start;
  assign resp_done  = done_q;
  assign resp_err   = (st == S_ERR);
  assign resp_code  = code_q;
  assign resp_tries = tries;
  assign rom_addr   = addr_q;
  assign rom_dq_out = data_q;
  assign rom_dq_oe  = hv_state;
  assign vpp_req    = hv_state;
  assign rom_ce_n   = !(rd_state || st == S_PULSE);
  assign rom_oe_n   = !rd_state;
  assign a9_hv_req  = (st == S_ID0) || (st == S_ID1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '1;
      tries  <= '0;
      code_q <= 2'd0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      cnt    <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (id_start) begin
            addr_q <= '0;
            tries  <= '0;
            st     <= S_ID0;
          end else if (req_valid) begin
            addr_q <= req_addr;
            data_q <= req_data;
            tries  <= '0;
            st     <= S_PRE;
          end
        end
        S_PRE: if (rd_ready) begin
          cnt <= '0;
          if (|(~rom_dq_in & data_q)) begin
            code_q <= 2'd1;
            st     <= S_ERR;
          end else if (rom_dq_in == data_q) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else st <= S_SET;
        end
        S_SET: begin
          cnt <= '0;
          st  <= S_PULSE;
        end
        S_PULSE: if (cnt == PULSE_END) begin
          cnt   <= '0;
          tries <= tries + 1'b1;
          st    <= S_REC;
        end
        S_REC: begin
          cnt <= '0;
          st  <= S_VER;
        end
        S_VER: if (rd_ready) begin
          cnt <= '0;
          if (rom_dq_in == data_q) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (tries == TRY_LIM) begin
            code_q <= 2'd2;
            st     <= S_ERR;
          end else st <= S_SET;
        end
        S_ID0: if (rd_ready) begin
          cnt <= '0;
          if (rom_dq_in != MFR_ID) begin
            code_q <= 2'd3;
            st     <= S_ERR;
          end else begin
            addr_q[0] <= 1'b1;
            st        <= S_ID1;
          end
        end
        S_ID1: if (rd_ready) begin
          cnt <= '0;
          if (rom_dq_in != DEV_ID) begin
            code_q <= 2'd3;
            st     <= S_ERR;
          end else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_ERR: if (err_ack) begin
          code_q <= 2'd0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_pulse_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE && $past(st) == S_PULSE) |-> ($stable(rom_addr) && $stable(rom_dq_out)));
  assert_vpp_before_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rom_ce_n) && vpp_req) |-> $past(vpp_req));
  assert_vpp_rise_ce_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_req) |-> rom_ce_n);
  assert_try_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_LIM);
  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_err));
  assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(resp_err) && !$past(err_ack)) |-> (resp_err && !req_ready));
  assert_no_vpp_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!vpp_req && rom_ce_n));
endmodule

// File: tb/tb_eprom_burner.sv
module tb_eprom_burner;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int PULSE_CYC = 10;
  localparam int DV_CYC = 3;
  localparam int MAX_TRY = 10;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, id_start = 1'b0, err_ack = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, resp_done, resp_err, rom_dq_oe, rom_ce_n, rom_oe_n, vpp_req, a9_hv_req;
  logic [1:0] resp_code;
  logic [TW-1:0] resp_tries;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_dq_out, rom_dq_in;

  always #4 clk = ~clk;

  eprom_burner #(.AW(AW), .DW(DW), .CLK_MHZ(125), .PULSE_NS(80), .DV_NS(24),
    .MAX_TRY(MAX_TRY)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .id_start(id_start), .err_ack(err_ack),
    .resp_done(resp_done), .resp_err(resp_err), .resp_code(resp_code),
    .resp_tries(resp_tries), .rom_addr(rom_addr), .rom_dq_out(rom_dq_out),
    .rom_dq_oe(rom_dq_oe), .rom_dq_in(rom_dq_in), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .vpp_req(vpp_req), .a9_hv_req(a9_hv_req));

  logic [7:0] mem [16];
  int pcount [16];
  int plen = 0, rdcnt = 0, bad_width = 0, bad_setup = 0, bad_stable = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdata = '0;
  logic prev_vpp = 1'b0, id_bad = 1'b0, seen_a9 = 1'b0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  function automatic int need(int a);
    return ((a * 5) % 13) + 1;
  endfunction

  function automatic logic [7:0] init_val(int a);
    if (a == 4) return 8'h7F;
    if (a == 9) return 8'hF0;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] tgt(int a);
    if (a == 2) return 8'hFF;
    if (a == 9) return 8'hF0;
    return 8'(a * 37 + 11);
  endfunction

  wire reading = !rom_ce_n && !rom_oe_n;
  wire pulsing = !rom_ce_n && vpp_req && rom_dq_oe && rom_oe_n;
  logic [7:0] true_val;
  always_comb begin
    if (a9_hv_req) true_val = rom_addr[0] ? (id_bad ? 8'h84 : 8'h85) : 8'h8F;
    else true_val = mem[rom_addr];
  end
  assign rom_dq_in = (reading && rdcnt >= DV_CYC) ? true_val : ~true_val;

  always @(posedge clk) begin
    rdcnt <= reading ? rdcnt + 1 : 0;
    prev_vpp <= vpp_req && rom_dq_oe;
    if (a9_hv_req && reading) seen_a9 <= 1'b1;
    if (pulsing) begin
      if (plen == 0 && !prev_vpp) bad_setup <= bad_setup + 1;
      if (plen > 0 && (rom_addr != paddr || rom_dq_out != pdata)) bad_stable <= bad_stable + 1;
      paddr <= rom_addr;
      pdata <= rom_dq_out;
      plen <= plen + 1;
    end else if (plen != 0) begin
      if (plen != PULSE_CYC) bad_width <= bad_width + 1;
      pcount[paddr] <= pcount[paddr] + 1;
      if (pcount[paddr] + 1 >= need(int'(paddr))) mem[paddr] <= mem[paddr] & pdata;
      plen <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  task automatic wait_resp();
    while (!(resp_done || resp_err)) @(negedge clk);
  endtask

  task automatic ack_err();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(resp_err && !req_ready, "R9 hold", {resp_err, req_ready}, 2'b10);
    end
    err_ack = 1'b1;
    @(negedge clk);
    err_ack = 1'b0;
    @(negedge clk);
    chk(req_ready, "R9 release", req_ready, 1);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) begin
      mem[a] = init_val(a);
      pcount[a] = 0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready && rom_ce_n && rom_oe_n && !vpp_req && !a9_hv_req && !rom_dq_oe
        && !resp_done && !resp_err, "R11 reset",
        {req_ready, rom_ce_n, rom_oe_n, vpp_req, a9_hv_req, rom_dq_oe, resp_done, resp_err},
        8'b11100000);
    rst_n = 1'b1;
    @(negedge clk);

    id_start = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1 ready low with id_start", req_ready, 0);
    id_start = 1'b0;
    wait_resp();
    chk(resp_done && resp_tries == 0 && seen_a9, "R10 id ok",
        {resp_done, seen_a9, resp_tries}, 6'h30);
    @(negedge clk);

    for (int a = 0; a < 16; a++) begin
      logic [7:0] cur, t;
      int exp_tries, exp_code;
      cur = init_val(a);
      t = tgt(a);
      if ((~cur & t) != 0) begin exp_code = 1; exp_tries = 0; end
      else if (cur == t) begin exp_code = 0; exp_tries = 0; end
      else if (need(a) <= MAX_TRY) begin exp_code = 0; exp_tries = need(a); end
      else begin exp_code = 2; exp_tries = MAX_TRY; end

      req_valid = 1'b1;
      req_addr = AW'(a);
      req_data = t;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R1 ready drops after accept", req_ready, 0);
      wait_resp();
      if (exp_code == 0) begin
        chk(resp_done && !resp_err, "R7 done", {resp_done, resp_err}, 2'b10);
        chk(int'(resp_tries) == exp_tries, exp_tries == 0 ? "R3 tries" : "R7 tries",
            resp_tries, exp_tries);
        chk(mem[a] == t, "R6 programmed byte", mem[a], t);
      end else begin
        chk(resp_err && int'(resp_code) == exp_code, exp_code == 1 ? "R2 code" : "R8 code",
            resp_code, exp_code);
        chk(int'(resp_tries) == exp_tries, exp_code == 1 ? "R2 tries" : "R8 tries",
            resp_tries, exp_tries);
      end
      chk(pcount[a] == exp_tries, "R8 pulse count", pcount[a], exp_tries);
      if (exp_code != 0) ack_err();
      else @(negedge clk);
    end

    chk(bad_width == 0, "R4 pulse width", bad_width, 0);
    chk(bad_setup == 0, "R4 vpp setup", bad_setup, 0);
    chk(bad_stable == 0, "R5 stable", bad_stable, 0);

    id_bad = 1'b1;
    id_start = 1'b1;
    @(negedge clk);
    id_start = 1'b0;
    wait_resp();
    chk(resp_err && resp_code == 2'd3, "R10 id mismatch", resp_code, 3);
    ack_err();
    summary();
  end
endmodule